// File: doc/BRIEF.md
# Push-Button Interrupt Flag Controller

This block watches a set of push-button levels and keeps one latched interrupt flag per button. A flag is set by the moment a button goes from released to pressed, not by a button being held. All flags share one active-low interrupt line to a host. While any flag is set, the line is low.

The host takes a snapshot of the flags with a read strobe. It clears a flag by writing a 1 into that button's bit of a clear register, then writes a 0 to re-arm it. The line is released as soon as the last flag is cleared, even if a button is still held. A press on another button while one is being serviced stays latched until the host clears it.

The button inputs must already be synchronised and debounced. The host bus protocol is outside this block.

Top module: `pb_irq_ctrl`

## Requirements
- R1: After reset the read register holds 0xF0 (bits [7:4] all 1, no flag set) and `irq_n` is high.
- R2: A released-to-pressed change of button n, seen at one clock edge, sets flag n at that edge, unless clear bit n is 1. A set flag reads as 0 in bit 4+n of the read register.
- R3: A button held pressed never sets its flag again. Only a new release followed by a press does.
- R4: `irq_n` is low exactly while at least one flag is set. It goes low in the cycle after the edge that sets the first flag.
- R5: A write with bit 4+n of `clr_wdata` at 1 loads clear bit n at that edge. Flag n is clear after the next edge. `irq_n` returns high if no other flag is set, even while the button is held.
- R6: While clear bit n holds 1, flag n stays clear and presses of button n are lost. Once 0 is written to that bit, a new press sets the flag again.
- R7: Flags are independent. A press of another button while one flag is being cleared stays latched, and `irq_n` stays low until that flag is cleared too.
- R8: At an edge with `rd_stb` high, the read register captures the inverted flags in bits [7:4] and 0 in bits [3:0]. Without `rd_stb` it holds its value.
- R9: Bits [3:0] of the write data have no effect. Write data presented with `clr_we` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_i | input | 4 | Button levels, 1 = pressed, synchronised and debounced |
| clr_we | input | 1 | Write strobe for the clear register |
| clr_wdata | input | 8 | Clear register data; bits [7:4] clear buttons 3..0 |
| rd_stb | input | 1 | Read strobe; captures the flag byte |
| rd_data | output | 8 | Captured flag byte, active-low flags in [7:4] |
| irq_n | output | 1 | Shared interrupt line, active low |

## Verification
The assertions assume that the button levels change only at clock edges and stay clean between them. In other words, they take the inputs as already synchronised and free of bounce. The stimulus changes buttons, strobes and write data only on the falling clock edge. Each button bit toggles only now and then, so presses, holds and releases all last several cycles. The assertions also assume that a clear bit is released by a later write. The random writes often carry zeros, so every clear bit is re-armed again.

// File: rtl/pbirq_pkg.sv
package pbirq_pkg;
    localparam int PB_COUNT  = 4;
    localparam int PB_DATA_W = 8;
endpackage

// File: rtl/pbirq_edge.sv
module pbirq_edge #(
    parameter int N = pbirq_pkg::PB_COUNT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] btn_i,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [N-1:0] prev;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = btn_i;
        rise_o    = btn_i & ~st_q.prev;
    end

    // Reset value "pressed": a button held through reset does not fire.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: '1};
        else        st_q <= st_d;
    end

    for (genvar n = 0; n < N; n++) begin : g_chk
        AST_EDGE_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[n] |-> !$past(btn_i[n])); // R3
    end
endmodule

// File: rtl/pbirq_clr.sv
module pbirq_clr #(
    parameter int N      = pbirq_pkg::PB_COUNT,
    parameter int DATA_W = pbirq_pkg::PB_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [N-1:0]      clr_o
);
    localparam int LSB = DATA_W - N;

    typedef struct packed {
        logic [N-1:0] clr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) st_d.clr = wdata_i[DATA_W-1:LSB];
        clr_o = st_q.clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{clr: '0};
        else        st_q <= st_d;
    end

    AST_CLR_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(clr_o)); // R9
    AST_CLR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> clr_o == $past(wdata_i[DATA_W-1:LSB])); // R5
endmodule

// File: rtl/pbirq_flags.sv
module pbirq_flags #(
    parameter int N = pbirq_pkg::PB_COUNT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int n = 0; n < N; n++) begin
            if (clr_i[n])       st_d.flag[n] = 1'b0;
            else if (rise_i[n]) st_d.flag[n] = 1'b1;
        end
        flag_o = st_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{flag: '0};
        else        st_q <= st_d;
    end

    for (genvar n = 0; n < N; n++) begin : g_chk
        AST_PRESS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (rise_i[n] && !clr_i[n]) |=> flag_o[n]); // R2
        AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i[n] |=> !flag_o[n]); // R6
        AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag_o[n] && !rise_i[n]) |=> !flag_o[n]); // R3
    end
endmodule

// File: rtl/pb_irq_ctrl.sv
module pb_irq_ctrl #(
    parameter int N      = pbirq_pkg::PB_COUNT,
    parameter int DATA_W = pbirq_pkg::PB_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      btn_i,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] clr_wdata,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_n
);
    localparam int LSB = DATA_W - N;
    localparam logic [DATA_W-1:0] RD_IDLE = {{N{1'b1}}, {LSB{1'b0}}};

    logic [N-1:0] rise, clr, flag;

    pbirq_edge #(.N(N)) u_edge (
        .clk(clk), .rst_n(rst_n), .btn_i(btn_i), .rise_o(rise)
    );

    pbirq_clr #(.N(N), .DATA_W(DATA_W)) u_clr (
        .clk(clk), .rst_n(rst_n), .we_i(clr_we), .wdata_i(clr_wdata), .clr_o(clr)
    );

    pbirq_flags #(.N(N)) u_flags (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .clr_i(clr), .flag_o(flag)
    );

    typedef struct packed {
        logic [DATA_W-1:0] rd;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_stb) st_d.rd = {~flag, {LSB{1'b0}}};
        rd_data = st_q.rd;
        irq_n   = ~|flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{rd: RD_IDLE};
        else        st_q <= st_d;
    end

    AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(|(rise & ~clr))); // R4
    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> $past(|clr)); // R5
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data)); // R8
    AST_RD_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[LSB-1:0] == '0); // R8
endmodule

// File: tb/pb_irq_ctrl_tb.sv
module pb_irq_ctrl_tb;
    localparam time CLK_HALF = 2ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] btn = '0;
    logic       we = 1'b0;
    logic [7:0] wd = '0;
    logic       rd = 1'b0;
    logic [7:0] rd_data;
    logic       irq_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // expected state after the next edge
    logic [3:0] m_flag, m_prev, m_clr;
    logic [7:0] m_rd;

    always #(CLK_HALF) clk = ~clk;

    pb_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .btn_i(btn), .clr_we(we), .clr_wdata(wd),
        .rd_stb(rd), .rd_data(rd_data), .irq_n(irq_n)
    );

    function automatic logic [3:0] f_next_flag(logic [3:0] f, logic [3:0] p,
                                               logic [3:0] c, logic [3:0] b);
        return ~c & (f | (b & ~p));
    endfunction

    task automatic check1(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(logic [3:0] b, logic w, logic [7:0] d, logic r);
        btn = b; we = w; wd = d; rd = r;
        if (r) m_rd = {~m_flag, 4'b0000};
        m_flag = f_next_flag(m_flag, m_prev, m_clr, b);
        if (w) m_clr = d[7:4];
        m_prev = b;
        @(posedge clk);
        @(negedge clk);
        check1("R4 irq_n", irq_n, ~|m_flag);
        check8("R8 rd_data", rd_data, m_rd);
    endtask

    task automatic rd_expect(string tag, logic [3:0] b, logic [7:0] exp);
        cyc(b, 1'b0, 8'h00, 1'b1);
        check8(tag, rd_data, exp);
    endtask

    initial begin
        m_flag = '0; m_prev = '1; m_clr = '0; m_rd = 8'hF0;
        repeat (3) @(negedge clk);
        check8("R1 rd_data", rd_data, 8'hF0);
        check1("R1 irq_n", irq_n, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        cyc(4'b0000, 0, 8'h00, 0);
        // R2: press button 0
        cyc(4'b0001, 0, 8'h00, 0);
        check1("R4 irq low", irq_n, 1'b0);
        rd_expect("R2 flag0 read", 4'b0001, 8'hE0);
        // R5: clear while held
        cyc(4'b0001, 1, 8'h10, 0);
        cyc(4'b0001, 1, 8'h00, 0);
        check1("R5 irq released", irq_n, 1'b1);
        // R3: hold does not re-set
        for (int i = 0; i < 5; i++) cyc(4'b0001, 0, 8'h00, 0);
        check1("R3 held no set", irq_n, 1'b1);
        rd_expect("R3 read", 4'b0001, 8'hF0);
        // R7: second press during servicing
        cyc(4'b0011, 0, 8'h00, 0);
        cyc(4'b0011, 1, 8'h20, 0);
        cyc(4'b0111, 0, 8'h00, 0);
        cyc(4'b0111, 1, 8'h00, 0);
        check1("R7 irq stays low", irq_n, 1'b0);
        rd_expect("R7 flag2 latched", 4'b0111, 8'hB0);
        cyc(4'b0111, 1, 8'h40, 0);
        cyc(4'b0111, 1, 8'h00, 0);
        check1("R7 irq released", irq_n, 1'b1);
        // R6: press lost while clear held
        cyc(4'b0000, 1, 8'h80, 0);
        cyc(4'b1000, 0, 8'h00, 0);
        cyc(4'b1000, 0, 8'h00, 0);
        check1("R6 held clear", irq_n, 1'b1);
        cyc(4'b1000, 1, 8'h00, 0);
        cyc(4'b1000, 0, 8'h00, 0);
        check1("R6 no edge after rearm", irq_n, 1'b1);
        cyc(4'b0000, 0, 8'h00, 0);
        cyc(4'b1000, 0, 8'h00, 0);
        check1("R6 press after rearm", irq_n, 1'b0);
        // R9: low nibble and idle writes ignored
        cyc(4'b1000, 1, 8'h0F, 0);
        cyc(4'b1000, 0, 8'hF0, 0);
        cyc(4'b1000, 0, 8'h00, 0);
        check1("R9 no clear", irq_n, 1'b0);
        rd_expect("R9 flag3 kept", 4'b1000, 8'h70);
        cyc(4'b1000, 1, 8'h80, 0);
        cyc(4'b1000, 1, 8'h00, 0);
        check1("R5 flag3 cleared", irq_n, 1'b1);
        // random phase
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] nb;
            logic [7:0] d;
            nb = btn;
            for (int k = 0; k < 4; k++)
                if ($urandom_range(7) == 0) nb[k] = ~nb[k];
            d = ($urandom_range(1) == 0) ? 8'h00 : 8'($urandom);
            cyc(nb, $urandom_range(5) == 0, d, $urandom_range(2) == 0);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule